// File: doc/BRIEF.md
# Priority Microtask Scheduler

This block lets one microsequencer serve sixteen fixed-priority microtasks. Every cycle it registers the per-task wakeup lines, merges them with a vector of tasks that are owed the processor, and picks the highest-numbered pending task. That choice, together with the saved program counter of the chosen task, is registered at the boundary between two pipeline stages. In the second stage the scheduler decides which task runs next and broadcasts that number on `next_task`, so that devices learn they are about to be served. It then presents the microstore address for the coming instruction.

Preemption costs no cycles. The saved-PC memory is written every cycle with the running task's computed successor address, so a task that loses the processor later resumes exactly where it stopped. A held instruction stores its own address, which makes the held instruction run again when its task comes back. Task 0 is treated as always requesting, so the sequencer always has a task to run.

Top module: `utask_sched`

## Requirements
- R1: Synchronous reset sets `cur_task`, `prev_task` and `uaddr` to 0, clears `switched`, clears every pending-ready bit, and makes every task's saved PC read as 0 until the task next runs.
- R2: Task 0 is always treated as requesting. With no wakeups at all, a blocking task hands the processor back to task 0.
- R3: Among pending tasks (wakeup bits or ready bits), the highest task number is chosen as the best candidate.
- R4: A wakeup bit driven before clock edge k first shows on `next_task` after edge k+1, and the task becomes `cur_task` after edge k+2.
- R5: When `block` is low or `hold` is high, `next_task` is the larger of the best candidate and `cur_task`.
- R6: When `block` is high and `hold` is low, `next_task` is the best candidate, even if it is lower than `cur_task`.
- R7: While `hold` is high, the address saved and reused for the running task is the current `uaddr` rather than `calc_next_pc`. A held task that keeps the processor repeats its address, and a held task that is preempted later resumes at the held address.
- R8: On every clock edge `cur_task` takes `next_task` and `prev_task` takes `cur_task`.
- R9: When `next_task` differs from `cur_task`, the next `uaddr` is the incoming task's saved PC and `switched` is set for one cycle. Otherwise the next `uaddr` is the running task's successor address and `switched` is low.
- R10: The running task's successor address is written into the saved-PC memory on every cycle. A read of that same entry in the same cycle returns the value being written.
- R11: A task that is switched away from without blocking gets its ready bit set. A pulse on `ready_cmd_en` sets the ready bit of `ready_cmd_task`. A ready bit is cleared in the cycle its task appears on `next_task`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wakeup | input | NUM_TASKS | Per-task service requests, bit n for task n |
| ready_cmd_en | input | 1 | Marks one task ready by command |
| ready_cmd_task | input | TASK_W | Task number to mark ready |
| calc_next_pc | input | PC_W | Successor address computed for the running instruction |
| block | input | 1 | Running task gives up the processor |
| hold | input | 1 | Running instruction must be repeated |
| uaddr | output | PC_W | Microstore address of the instruction now running |
| next_task | output | TASK_W | Task that runs in the following cycle |
| cur_task | output | TASK_W | Task that owns the current instruction |
| prev_task | output | TASK_W | Task that owned the previous instruction |
| switched | output | 1 | Current instruction is the first after a task change |

## Verification
The assertions assume that `block`, `hold` and the ready command are stable, known values around each rising edge. They also assume `calc_next_pc` depends only on the running instruction. The bench meets this by changing inputs only on the falling edge, and it derives `calc_next_pc` from `uaddr` plus one, so every expected address can be worked out in advance. Device behaviour is modelled by dropping a wakeup once the task has been announced on `next_task`. This keeps the two-cycle latency inside the sequences the assertions cover.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned DEF_TASKS = 16;
  localparam int unsigned DEF_PC_W  = 12;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sched_req_track.sv
module sched_req_track #(
  parameter int unsigned NUM_TASKS = 16,
  parameter int unsigned TASK_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] wakeup,
  input  logic                 cmd_en,
  input  logic [TASK_W-1:0]    cmd_task,
  input  logic                 preempt,
  input  logic [TASK_W-1:0]    preempt_task,
  input  logic [TASK_W-1:0]    sel_task,
  output logic [NUM_TASKS-1:0] pending
);
  logic [NUM_TASKS-1:0] wake_q;
  logic [NUM_TASKS-1:0] ready_q;
  logic [NUM_TASKS-1:0] ready_d;
  logic [NUM_TASKS-1:0] sel_mask;

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_bit
    assign sel_mask[t] = (sel_task == TASK_W'(t));
    always_comb begin
      ready_d[t] = ready_q[t] & ~sel_mask[t];
      if (preempt && preempt_task == TASK_W'(t)) ready_d[t] = 1'b1;
      if (cmd_en && cmd_task == TASK_W'(t))       ready_d[t] = 1'b1;
    end
    if (t == 0) begin : g_base
      always_ff @(posedge clk) begin
        if (rst) wake_q[t] <= 1'b1;
        else     wake_q[t] <= 1'b1;
      end
    end else begin : g_dev
      always_ff @(posedge clk) begin
        if (rst) wake_q[t] <= 1'b0;
        else     wake_q[t] <= wakeup[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ready_q <= '0;
    else     ready_q <= ready_d;
  end

  // a task already chosen for the coming cycle is not offered again
  assign pending = wake_q | (ready_q & ~sel_mask);

  // R11
  preempted_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (preempt && !(cmd_en && cmd_task == sel_task)) |=> ready_q[$past(preempt_task)]);

  // R2
  base_task_pending_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pending[0]);
endmodule

// File: rtl/sched_prio_enc.sv
module sched_prio_enc #(
  parameter int unsigned NUM_TASKS = 16,
  parameter int unsigned TASK_W    = 4
) (
  input  logic [NUM_TASKS-1:0] req,
  output logic [TASK_W-1:0]    best
);
  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (req[i]) best = TASK_W'(i);
    end
  end
endmodule

// File: rtl/sched_pc_mem.sv
module sched_pc_mem #(
  parameter int unsigned NUM_TASKS = 16,
  parameter int unsigned TASK_W    = 4,
  parameter int unsigned PC_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TASK_W-1:0] wr_task,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [TASK_W-1:0] rd_task,
  output logic [PC_W-1:0]   rd_pc
);
  logic [PC_W-1:0]      mem [NUM_TASKS];
  logic [NUM_TASKS-1:0] valid_q;
  logic [PC_W-1:0]      rd_q;
  logic [PC_W-1:0]      byp_q;
  logic                 hit_q;
  logic                 vld_q;

  // plain array with one write and one registered read port
  always_ff @(posedge clk) begin
    mem[wr_task] <= wr_pc;
    rd_q         <= mem[rd_task];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      hit_q   <= 1'b0;
      vld_q   <= 1'b0;
      byp_q   <= '0;
    end else begin
      valid_q[wr_task] <= 1'b1;
      hit_q            <= (rd_task == wr_task);
      vld_q            <= valid_q[rd_task];
      byp_q            <= wr_pc;
    end
  end

  always_comb begin
    if (hit_q)      rd_pc = byp_q;
    else if (vld_q) rd_pc = rd_q;
    else            rd_pc = '0;
  end

  // R10
  same_entry_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_task == wr_task) |=> rd_pc == $past(wr_pc));
endmodule

// File: rtl/utask_sched.sv
module utask_sched
  import sched_pkg::*;
#(
  parameter int unsigned NUM_TASKS = DEF_TASKS,
  parameter int unsigned PC_W      = DEF_PC_W,
  localparam int unsigned TASK_W   = idx_width(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] wakeup,
  input  logic                 ready_cmd_en,
  input  logic [TASK_W-1:0]    ready_cmd_task,
  input  logic [PC_W-1:0]      calc_next_pc,
  input  logic                 block,
  input  logic                 hold,
  output logic [PC_W-1:0]      uaddr,
  output logic [TASK_W-1:0]    next_task,
  output logic [TASK_W-1:0]    cur_task,
  output logic [TASK_W-1:0]    prev_task,
  output logic                 switched
);
  logic [NUM_TASKS-1:0] pending;
  logic [TASK_W-1:0]    enc_best;
  logic [TASK_W-1:0]    best_q;
  logic [PC_W-1:0]      best_pc;
  logic [PC_W-1:0]      eff_pc;
  logic                 give_up;
  logic                 change;
  logic                 preempt;

  // stage 1: request capture and ranking
  sched_req_track #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W)) u_req (
    .clk(clk), .rst(rst), .wakeup(wakeup),
    .cmd_en(ready_cmd_en), .cmd_task(ready_cmd_task),
    .preempt(preempt), .preempt_task(cur_task),
    .sel_task(next_task), .pending(pending)
  );

  sched_prio_enc #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W)) u_enc (
    .req(pending), .best(enc_best)
  );

  sched_pc_mem #(.NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W), .PC_W(PC_W)) u_pcs (
    .clk(clk), .rst(rst),
    .wr_task(cur_task), .wr_pc(eff_pc),
    .rd_task(enc_best), .rd_pc(best_pc)
  );

  // stage 2: selection of the following task
  assign give_up   = block & ~hold;
  assign next_task = give_up ? best_q : ((best_q > cur_task) ? best_q : cur_task);
  assign change    = (next_task != cur_task);
  assign preempt   = change & ~give_up;
  assign eff_pc    = hold ? uaddr : calc_next_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      best_q    <= '0;
      cur_task  <= '0;
      prev_task <= '0;
      uaddr     <= '0;
      switched  <= 1'b0;
    end else begin
      best_q    <= enc_best;
      cur_task  <= next_task;
      prev_task <= cur_task;
      uaddr     <= change ? best_pc : eff_pc;
      switched  <= change;
    end
  end

  // R3
  highest_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (|pending) |-> (pending[enc_best] && ((pending >> enc_best) == NUM_TASKS'(1))));

  // R5
  no_lower_unless_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!block || hold) |-> next_task >= cur_task);

  // R6
  block_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (block && !hold && best_q < cur_task) |=> switched);

  // R7
  hold_repeats_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && next_task == cur_task) |=> uaddr == $past(uaddr));

  // R8
  task_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cur_task == $past(next_task)) && (prev_task == $past(cur_task)));
endmodule

// File: tb/utask_sched_test.sv
module utask_sched_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wakeup = '0;
  logic        ready_cmd_en = 1'b0;
  logic [3:0]  ready_cmd_task = '0;
  logic [11:0] calc_next_pc;
  logic        block = 1'b0;
  logic        hold = 1'b0;
  logic [11:0] uaddr;
  logic [3:0]  next_task, cur_task, prev_task;
  logic        switched;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // successor address: next sequential word
  assign calc_next_pc = uaddr + 12'd1;

  utask_sched uut (
    .clk(clk), .rst(rst), .wakeup(wakeup),
    .ready_cmd_en(ready_cmd_en), .ready_cmd_task(ready_cmd_task),
    .calc_next_pc(calc_next_pc), .block(block), .hold(hold),
    .uaddr(uaddr), .next_task(next_task), .cur_task(cur_task),
    .prev_task(prev_task), .switched(switched)
  );

  function automatic logic [47:0] v(input logic [15:0] w, input logic b, input logic h,
      input logic re, input logic [3:0] rt, input logic [3:0] cu, input logic [3:0] pv,
      input logic [11:0] ua, input logic [3:0] nx, input logic sw);
    return {w, b, h, re, rt, cu, pv, ua, nx, sw};
  endfunction

  // wake, block, hold, cmd, cmd task | cur, prev, uaddr, next, switched
  localparam logic [47:0] VEC [NV] = '{
    v(16'h0020,0,0,0,0,  0,0, 1, 0,0),  // R4 wake 5 registered
    v(16'h0020,0,0,0,0,  0,0, 2, 5,0),  // R4 R5 announced after two edges
    v(16'h0000,0,0,0,0,  5,0, 0, 5,1),  // R9 R11 switch, task 0 marked ready
    v(16'h0000,1,0,0,0,  5,5, 1, 0,0),  // R6 stale best keeps 5 one more cycle
    v(16'h0000,1,0,0,0,  0,5, 3, 0,1),  // R2 R10 task 0 resumes at 3
    v(16'h0100,0,0,0,0,  0,0, 4, 0,0),  // R10 bypassed self read
    v(16'h0100,0,0,0,0,  0,0, 5, 8,0),  // R3 wake 8 ranked
    v(16'h0000,0,1,0,0,  8,0, 0, 8,1),  // R7 preempt during hold
    v(16'h0000,0,0,0,0,  8,8, 1, 8,0),  // R5 max keeps 8
    v(16'h0000,1,1,0,0,  8,8, 1, 8,0),  // R7 hold ignores block, repeats address
    v(16'h0000,1,0,0,0,  0,8, 5, 0,1),  // R7 held address 5 resumes
    v(16'h0000,0,0,1,3,  0,0, 6, 0,0),  // R11 command marks task 3
    v(16'h0000,0,0,0,0,  0,0, 7, 3,0),  // R11 ready bit ranked
    v(16'h0000,0,0,0,0,  3,0, 0, 3,1),  // R9 switch to 3
    v(16'h0000,1,0,0,0,  0,3, 8, 0,1),  // R10 task 0 saved 8 via bypass
    v(16'h0840,0,0,0,0,  0,0, 9, 0,0),  // R3 two wakes
    v(16'h0840,0,0,0,0,  0,0,10,11,0),  // R3 highest wins
    v(16'h0040,0,0,0,0, 11,0, 0,11,1),  // R8 R9
    v(16'h0040,0,0,0,0, 11,11,1,11,0),  // R5 lower 6 does not preempt
    v(16'h0000,1,0,0,0,  6,11,0, 6,1)   // R6 block drops to lower 6
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "cur_task", cur_task, 0);
    check("R1", "prev_task", prev_task, 0);
    check("R1", "uaddr", uaddr, 0);
    check("R1", "switched", switched, 0);
    check("R1", "next_task", next_task, 0);

    for (int i = 0; i < NV; i++) begin
      wakeup         = VEC[i][47:32];
      block          = VEC[i][31];
      hold           = VEC[i][30];
      ready_cmd_en   = VEC[i][29];
      ready_cmd_task = VEC[i][28:25];
      @(posedge clk);
      @(negedge clk);
      ready_cmd_en = 1'b0;
      check("R8", "cur_task", cur_task, int'(VEC[i][24:21]));
      check("R8", "prev_task", prev_task, int'(VEC[i][20:17]));
      check("R9", "uaddr", uaddr, int'(VEC[i][16:5]));
      check("R5", "next_task", next_task, int'(VEC[i][4:1]));
      check("R9", "switched", switched, int'(VEC[i][0]));
    end

    // R1: reset clears saved PCs (task 11 had saved 2 before)
    block = 1'b0; hold = 1'b0; wakeup = '0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "cur_task after reset", cur_task, 0);
    wakeup = 16'h0800;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R4", "next_task after two edges", next_task, 11);
    wakeup = 16'h0000;
    @(posedge clk); @(negedge clk);
    check("R1", "cur_task resumed", cur_task, 11);
    check("R1", "saved PC of task 11 after reset", uaddr, 0);

    // R3: every task requesting ranks task 15 first
    wakeup = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R3", "next_task all requesting", next_task, 15);

    // R2: with no wakeups a blocking task returns to task 0
    wakeup = 16'h0000;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    block = 1'b1;
    repeat (4) begin
      @(posedge clk); @(negedge clk);
    end
    check("R2", "cur_task falls to task 0", cur_task, 0);
    block = 1'b0;

    finish_run();
  end
endmodule